// File: doc/BRIEF.md
# Macro Processor ALU with Bitfield Operations

This block is the arithmetic stage of a small macro processor that runs command programs. Each cycle it is given a three-bit operation selector, the upper eighteen bits of the instruction word (these bits hold the immediate and the bitfield fields), and two 32-bit register operands. It returns a result in the same cycle. The supported work is register arithmetic and logic, add-immediate, three bitfield forms (insert, extract with an immediate-placed left shift, extract with a register-placed left shift), and a read of an engine register at operand A plus the immediate. Branch evaluation, register-file writes and routing of the result are done elsewhere.

The only stored state is a carry flag. It resets to zero. It is written on a clock edge only while `op_en` is high and only by the four carry-producing register sub-operations. The register read toward the engine is a plain combinational request and response: the block drives the address and a strobe, and the engine returns data within the same cycle. No handshake is involved.

Top module: `mac_alu`

## Requirements
- R1: `op_sel` selects the operation: 0 register ALU, 1 add immediate, 2 bitfield insert, 3 extract with immediate left shift, 4 extract with register left shift, 5 engine read. For values 6 and 7 the result is 0, `eng_rd_en` stays low and the carry is left as it is.
- R2: Register sub-operation 0 (add) returns A+B and sets the carry to the unsigned 32-bit overflow. Sub-operation 1 also adds 1 when the stored carry is set.
- R3: Sub-operation 2 returns A−B and sets the carry when no borrow occurred, that is when A ≥ B unsigned. Sub-operation 3 also subtracts 1 when the stored carry is clear, and sets the carry when A ≥ B + (1 − carry).
- R4: Sub-operations 8 XOR, 9 OR, 10 AND, 11 A AND NOT B and 12 NOT(A AND B) return the named logic function and leave the carry unchanged.
- R5: Every other register sub-operation code returns 0 and leaves the carry unchanged.
- R6: The immediate is `op_field` (instruction bits 31:14) sign-extended to 32 bits. Add-immediate returns A + immediate and leaves the carry unchanged.
- R7: The bitfield fields are source position `op_field[7:3]` (instruction bits 21:17), size `op_field[12:8]` (bits 26:22) and destination position `op_field[17:13]` (bits 31:27). The mask is 2^size − 1. The register sub-operation code is the same field as the source position. Insert takes size bits of B starting at the source position, places them in A at the destination position, and keeps every other bit of A.
- R8: Extract with immediate shift returns ((B >> A[4:0]) AND mask) << destination position.
- R9: Extract with register shift returns ((B >> source position) AND mask) << A[4:0].
- R10: For an engine read, `eng_rd_addr` is A + immediate, `eng_rd_en` is high exactly when `op_en` is high, and `result` equals `eng_rd_data` in the same cycle.
- R11: The carry flag is 0 after reset. It changes only on a clock edge with `op_en` high. Sub-operations 1 and 3 use the stored flag, and `carry_flag` shows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_en | input | 1 | Operation issued this cycle; enables the carry update and the engine read |
| op_sel | input | 3 | Operation selector, instruction bits 2:0 |
| op_field | input | 18 | Instruction bits 31:14: the immediate and the bitfield fields |
| src_a | input | 32 | Operand A |
| src_b | input | 32 | Operand B |
| eng_rd_data | input | 32 | Engine register read data, combinational |
| eng_rd_en | output | 1 | Engine read strobe |
| eng_rd_addr | output | 32 | Engine register address |
| result | output | 32 | Operation result |
| carry_flag | output | 1 | Stored carry flag |

## Verification
The assertions assume that every input is a known value at each rising edge. They also assume that the engine returns `eng_rd_data` combinationally from `eng_rd_addr`, so the value routed to the result is the value seen in that cycle. The bench changes inputs only at falling edges, samples the result one time unit later and samples the carry after the following rising edge. It models the engine as a fixed function of the address, so each read response is known before it is checked.

// File: rtl/mac_alu_pkg.sv
package mac_alu_pkg;

    // instruction bits 31:14 arrive as op_field; positions below are within op_field
    localparam int SEL_W     = 3;
    localparam int FIELD_W   = 18;
    localparam int FLD_W     = 5;
    localparam int LO_LSB    = 3;    // instruction bit 17
    localparam int SIZE_LSB  = 8;    // instruction bit 22
    localparam int DPOS_LSB  = 13;   // instruction bit 27

    typedef enum logic [SEL_W-1:0] {
        SEL_REG     = 3'd0,
        SEL_ADDI    = 3'd1,
        SEL_BF_INS  = 3'd2,
        SEL_BF_XIMM = 3'd3,
        SEL_BF_XREG = 3'd4,
        SEL_ENG_RD  = 3'd5,
        SEL_RSV6    = 3'd6,
        SEL_BRANCH  = 3'd7
    } op_sel_e;

    typedef enum logic [FLD_W-1:0] {
        FN_ADD  = 5'd0,
        FN_ADC  = 5'd1,
        FN_SUB  = 5'd2,
        FN_SBB  = 5'd3,
        FN_XOR  = 5'd8,
        FN_OR   = 5'd9,
        FN_AND  = 5'd10,
        FN_ANDN = 5'd11,
        FN_NAND = 5'd12
    } reg_fn_e;

    typedef struct packed {
        op_sel_e            sel;
        logic [FLD_W-1:0]   fld_lo;
        logic [FLD_W-1:0]   fld_size;
        logic [FLD_W-1:0]   fld_dpos;
        logic [FIELD_W-1:0] imm;
    } opc_fields_t;

endpackage

// File: rtl/mac_alu_decode.sv
module mac_alu_decode
    import mac_alu_pkg::*;
(
    input  logic [SEL_W-1:0]   op_sel,
    input  logic [FIELD_W-1:0] op_field,
    output opc_fields_t        fields
);

    always_comb begin
        fields.sel      = op_sel_e'(op_sel);
        fields.fld_lo   = op_field[LO_LSB   +: FLD_W];
        fields.fld_size = op_field[SIZE_LSB +: FLD_W];
        fields.fld_dpos = op_field[DPOS_LSB +: FLD_W];
        fields.imm      = op_field;
    end

endmodule

// File: rtl/mac_alu_regops.sv
module mac_alu_regops
    import mac_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLD_W-1:0]  fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              carry_in,
    output logic [DATA_W-1:0] res,
    output logic              carry_nxt,
    output logic              carry_we
);

    localparam int EXT_W = DATA_W + 1;

    reg_fn_e          fn_e;
    logic             add_cin;
    logic             sub_bin;
    logic [EXT_W-1:0] sum_x;
    logic [EXT_W-1:0] dif_x;

    assign fn_e    = reg_fn_e'(fn);
    assign add_cin = (fn_e == FN_ADC) && carry_in;
    assign sub_bin = (fn_e == FN_SBB) && !carry_in;

    always_comb begin
        sum_x = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, add_cin};
        dif_x = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, sub_bin};
    end

    always_comb begin
        res       = '0;
        carry_nxt = carry_in;
        carry_we  = 1'b0;
        case (fn_e)
            FN_ADD, FN_ADC: begin
                res       = sum_x[DATA_W-1:0];
                carry_nxt = sum_x[DATA_W];
                carry_we  = 1'b1;
            end
            FN_SUB, FN_SBB: begin
                res       = dif_x[DATA_W-1:0];
                carry_nxt = ~dif_x[DATA_W];
                carry_we  = 1'b1;
            end
            FN_XOR:  res = a ^ b;
            FN_OR:   res = a | b;
            FN_AND:  res = a & b;
            FN_ANDN: res = a & ~b;
            FN_NAND: res = ~(a & b);
            default: res = '0;
        endcase
    end

    p_add_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_e == FN_ADD) |-> (carry_nxt == (res < a)));

    p_sub_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_e == FN_SUB) |-> (carry_nxt == (a >= b)));

    p_logic_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fn >= 5'd8) |-> !carry_we);

    p_undef_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((fn >= 5'd4 && fn <= 5'd7) || fn >= 5'd13) |-> (res == '0 && !carry_we));

endmodule

// File: rtl/mac_alu_bitfield.sv
module mac_alu_bitfield
    import mac_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_sel_e           sel,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [FLD_W-1:0]  src_pos,
    input  logic [FLD_W-1:0]  fsize,
    input  logic [FLD_W-1:0]  dpos,
    output logic [DATA_W-1:0] res
);

    localparam int SHW = $clog2(DATA_W);

    logic [DATA_W-1:0] mask_v;
    logic [DATA_W-1:0] mask_at_dst;
    logic [SHW-1:0]    a_sh;
    logic [DATA_W-1:0] fld_fixed;
    logic [DATA_W-1:0] fld_var;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask_v[i] = (int'(fsize) > i);
    end

    assign a_sh        = a[SHW-1:0];
    assign mask_at_dst = mask_v << dpos;
    assign fld_fixed   = (b >> src_pos) & mask_v;
    assign fld_var     = (b >> a_sh) & mask_v;

    always_comb begin
        unique case (sel)
            SEL_BF_INS:  res = (a & ~mask_at_dst) | (fld_fixed << dpos);
            SEL_BF_XIMM: res = fld_var << dpos;
            SEL_BF_XREG: res = fld_fixed << a_sh;
            default:     res = '0;
        endcase
    end

    p_ins_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_BF_INS) |-> (((res ^ a) & ~mask_at_dst) == '0));

    p_ximm_confine_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_BF_XIMM) |-> ((res & ~mask_at_dst) == '0));

    p_xreg_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_BF_XREG) |-> ((res & ((DATA_W'(1) << a_sh) - DATA_W'(1))) == '0));

endmodule

// File: rtl/mac_alu.sv
module mac_alu
    import mac_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_en,
    input  logic [SEL_W-1:0]   op_sel,
    input  logic [FIELD_W-1:0] op_field,
    input  logic [DATA_W-1:0]  src_a,
    input  logic [DATA_W-1:0]  src_b,
    input  logic [DATA_W-1:0]  eng_rd_data,
    output logic               eng_rd_en,
    output logic [DATA_W-1:0]  eng_rd_addr,
    output logic [DATA_W-1:0]  result,
    output logic               carry_flag
);

    localparam int PAD_W = DATA_W - FIELD_W;

    opc_fields_t       f;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] rg_res;
    logic              rg_carry;
    logic              rg_we;
    logic [DATA_W-1:0] bf_res;
    logic              carry_q;

    mac_alu_decode u_decode (
        .op_sel   (op_sel),
        .op_field (op_field),
        .fields   (f)
    );

    mac_alu_regops #(.DATA_W(DATA_W)) u_regops (
        .clk       (clk),
        .rst_n     (rst_n),
        .fn        (f.fld_lo),
        .a         (src_a),
        .b         (src_b),
        .carry_in  (carry_q),
        .res       (rg_res),
        .carry_nxt (rg_carry),
        .carry_we  (rg_we)
    );

    mac_alu_bitfield #(.DATA_W(DATA_W)) u_bitfield (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (f.sel),
        .a       (src_a),
        .b       (src_b),
        .src_pos (f.fld_lo),
        .fsize   (f.fld_size),
        .dpos    (f.fld_dpos),
        .res     (bf_res)
    );

    assign imm_ext     = {{PAD_W{f.imm[FIELD_W-1]}}, f.imm};
    assign eng_rd_addr = src_a + imm_ext;
    assign eng_rd_en   = op_en && (f.sel == SEL_ENG_RD);

    always_comb begin
        unique case (f.sel)
            SEL_REG:                             result = rg_res;
            SEL_ADDI:                            result = src_a + imm_ext;
            SEL_BF_INS, SEL_BF_XIMM, SEL_BF_XREG: result = bf_res;
            SEL_ENG_RD:                          result = eng_rd_data;
            SEL_RSV6, SEL_BRANCH:                result = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (op_en && (f.sel == SEL_REG) && rg_we) begin
            carry_q <= rg_carry;
        end
    end

    assign carry_flag = carry_q;

    p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel >= 3'd6) |-> (result == '0 && !eng_rd_en));

    p_nonreg_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_en && op_sel != 3'd0) |=> $stable(carry_flag));

    p_rd_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rd_en |-> (result == eng_rd_data && op_sel == 3'd5));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !op_en |=> $stable(carry_flag));

endmodule

// File: tb/mac_alu_tb.sv
module mac_alu_tb;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RD_KEY     = 32'hA5C3_0F1E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_en = 1'b0;
    logic [2:0]  op_sel = 3'd0;
    logic [17:0] op_field = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] eng_rd_data;
    logic        eng_rd_en;
    logic [31:0] eng_rd_addr;
    logic [31:0] result;
    logic        carry_flag;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic mcarry = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign eng_rd_data = eng_rd_addr ^ RD_KEY;

    mac_alu u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_en       (op_en),
        .op_sel      (op_sel),
        .op_field    (op_field),
        .src_a       (src_a),
        .src_b       (src_b),
        .eng_rd_data (eng_rd_data),
        .eng_rd_en   (eng_rd_en),
        .eng_rd_addr (eng_rd_addr),
        .result      (result),
        .carry_flag  (carry_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_calc(input logic [31:0] w, input logic [31:0] a,
                                             input logic [31:0] b, input logic cin,
                                             output logic cwe, output logic cnew);
        logic [63:0] t, m, ax, bx;
        logic [31:0] imm;
        int sz, sp, dp, sa;
        ax   = {32'd0, a};
        bx   = {32'd0, b};
        sz   = int'(w[26:22]);
        sp   = int'(w[21:17]);
        dp   = int'(w[31:27]);
        sa   = int'(a[4:0]);
        m    = (64'd1 << sz) - 64'd1;
        imm  = {{14{w[31]}}, w[31:14]};
        cwe  = 1'b0;
        cnew = cin;
        ref_calc = 32'd0;
        case (w[2:0])
            3'd0: case (w[21:17])
                5'd0: begin t = ax + bx; ref_calc = t[31:0]; cwe = 1'b1; cnew = (t > 64'hFFFF_FFFF); end
                5'd1: begin t = ax + bx + {63'd0, cin}; ref_calc = t[31:0]; cwe = 1'b1; cnew = (t > 64'hFFFF_FFFF); end
                5'd2: begin ref_calc = a - b; cwe = 1'b1; cnew = (a >= b); end
                5'd3: begin
                    t = bx + (cin ? 64'd0 : 64'd1);
                    cwe = 1'b1;
                    cnew = (ax >= t);
                    ref_calc = a - b - (cin ? 32'd0 : 32'd1);
                end
                5'd8:  ref_calc = a ^ b;
                5'd9:  ref_calc = a | b;
                5'd10: ref_calc = a & b;
                5'd11: ref_calc = a & ~b;
                5'd12: ref_calc = ~(a & b);
                default: ref_calc = 32'd0;
            endcase
            3'd1: ref_calc = a + imm;
            3'd2: begin t = (ax & ~(m << dp)) | (((bx >> sp) & m) << dp); ref_calc = t[31:0]; end
            3'd3: begin t = ((bx >> sa) & m) << dp; ref_calc = t[31:0]; end
            3'd4: begin t = ((bx >> sp) & m) << sa; ref_calc = t[31:0]; end
            3'd5: ref_calc = (a + imm) ^ RD_KEY;
            default: ref_calc = 32'd0;
        endcase
    endfunction

    task automatic do_op(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                         input logic en, input string tag);
        logic [31:0] exp;
        logic cwe, cnew;
        @(negedge clk);
        op_en    = en;
        op_sel   = w[2:0];
        op_field = w[31:14];
        src_a    = a;
        src_b    = b;
        #1;
        exp = ref_calc(w, a, b, mcarry, cwe, cnew);
        chk(tag, result, exp);
        chk({tag, " R10 strobe"}, {31'd0, eng_rd_en}, {31'd0, en && (w[2:0] == 3'd5)});
        if (w[2:0] == 3'd5)
            chk("R10 addr", eng_rd_addr, a + {{14{w[31]}}, w[31:14]});
        @(posedge clk);
        #1;
        if (en && cwe) mcarry = cnew;
        chk({tag, " R11 carry"}, {31'd0, carry_flag}, {31'd0, mcarry});
    endtask

    function automatic logic [63:0] pair(input int k);
        case (k)
            0: pair = {32'h0000_0000, 32'h0000_0000};
            1: pair = {32'h0000_0001, 32'h0000_0001};
            2: pair = {32'hFFFF_FFFF, 32'h0000_0001};
            3: pair = {32'hFFFF_FFFF, 32'hFFFF_FFFF};
            4: pair = {32'h8000_0000, 32'h8000_0000};
            5: pair = {32'h1234_5678, 32'h9ABC_DEF0};
            6: pair = {32'h0000_0005, 32'h0000_0007};
            default: pair = {32'h0000_0007, 32'h0000_0005};
        endcase
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset carry", {31'd0, carry_flag}, 32'd0);
        chk("R10 reset strobe", {31'd0, eng_rd_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // register ALU: every sub-operation code, operand pairs, both carry states
        for (int fn = 0; fn < 32; fn++) begin
            for (int k = 0; k < 8; k++) begin
                for (int c = 0; c < 2; c++) begin
                    logic [63:0] p;
                    string tg;
                    p = pair(k);
                    do_op(32'd2 << 17, (c != 0) ? 32'd5 : 32'd0, (c != 0) ? 32'd3 : 32'd1, 1'b1, "R3 preset");
                    if (fn < 2)       tg = "R2";
                    else if (fn < 4)  tg = "R3";
                    else if (fn >= 8 && fn <= 12) tg = "R4";
                    else              tg = "R5";
                    do_op(32'(fn) << 17, p[63:32], p[31:0], 1'b1, tg);
                end
            end
        end

        // op_en low: carry-producing operation must not change the flag
        do_op(32'd2 << 17, 32'd9, 32'd1, 1'b1, "R3 set");
        do_op(32'd2 << 17, 32'd0, 32'd1, 1'b0, "R11 idle sub");
        do_op(32'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, "R11 idle add");

        // add immediate with sign extension
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 4; j++) begin
                logic [17:0] im;
                logic [31:0] av;
                case (i)
                    0: im = 18'h00000;
                    1: im = 18'h00001;
                    2: im = 18'h1FFFF;
                    3: im = 18'h20000;
                    4: im = 18'h3FFFF;
                    default: im = 18'h12345;
                endcase
                av = 32'h7FFF_FFF0 + 32'(j) * 32'h4000_0011;
                do_op({im, 11'd0, 3'd1}, av, 32'hDEAD_0000, 1'b1, "R6");
            end
        end

        // bitfield forms: all sizes and destination positions
        for (int form = 2; form <= 4; form++) begin
            for (int sz = 0; sz < 32; sz++) begin
                for (int dp = 0; dp < 32; dp++) begin
                    logic [31:0] w, a, b;
                    int sp;
                    string tg;
                    sp = (sz * 7 + dp) % 32;
                    w  = (32'(dp) << 27) | (32'(sz) << 22) | (32'(sp) << 17) | 32'(form);
                    a  = 32'hDEAD_BE00 ^ 32'(sz * 5 + dp * 3);
                    b  = 32'h9E37_79B9 ^ (32'(dp) << 11) ^ 32'(sz);
                    tg = (form == 2) ? "R7" : (form == 3) ? "R8" : "R9";
                    do_op(w, a, b, 1'b1, tg);
                end
            end
        end

        // engine read: positive and negative immediates, strobe gated by op_en
        for (int i = 0; i < 8; i++) begin
            logic [17:0] im;
            im = (i % 2 == 0) ? 18'(i * 37) : 18'h3FFFF - 18'(i);
            do_op({im, 11'd0, 3'd5}, 32'h0000_1000 + 32'(i * 4), 32'd0, 1'b1, "R10");
        end
        do_op({18'h00010, 11'd0, 3'd5}, 32'h40, 32'd0, 1'b0, "R10 idle");

        // reserved selectors with carry set
        do_op(32'd2 << 17, 32'd4, 32'd4, 1'b1, "R3 set");
        do_op({18'h3FFFF, 11'h7FF, 3'd6}, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R1 sel6");
        do_op({18'h2AAAA, 11'h555, 3'd7}, 32'h1234_5678, 32'h1, 1'b1, "R1 sel7");

        // reset in mid-run clears the carry
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R11 mid reset", {31'd0, carry_flag}, 32'd0);
        mcarry = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        do_op(32'd1 << 17, 32'hFFFF_FFFF, 32'd0, 1'b1, "R2 adc after reset");

        finish_run();
    end

endmodule